// File: doc/BRIEF.md
# Ordered Queue Ticket Checker

This block watches the two ends of an in-order queue: the enqueue side, where entries go in, and the dequeue side, where they come out. It proves that they come out in the same order and with the same data. Each accepted enqueue takes the next value of a 16-bit ticket counter, and its data byte is kept in a small store. A second 16-bit counter names the entry that is being served. The next dequeue is compared only with that entry. When the dequeue arrives, the dequeued byte is compared with the stored byte, and the block reports a match or a mismatch. If the entry has waited a full window of clocks without being dequeued, the block reports a late error instead. In all three cases the serving counter moves on to the next entry, so one bad or lost item does not hide the items behind it.

The block only observes. `enq_fire` and `deq_fire` are the completed-transfer strobes of the queue being watched, taken as valid-and-ready on each side. The checker drives no ready signal and never applies back-pressure. It accepts an event on each side in every cycle, and it may see both in the same cycle. All result outputs are single-cycle pulses, registered one clock after the event that causes them.

Top module: `ordq_ticket_checker`

## Requirements
- R1: A synchronous reset clears both counters, empties the store and drives all five result outputs low. A dequeue right after reset reports an underflow.
- R2: If a dequeue arrives while an entry is being served and `deq_data` equals that entry's stored byte, `match_ok` pulses in the next cycle.
- R3: If the bytes differ, `mismatch_err` pulses in the next cycle and the entry is retired all the same.
- R4: Entries are served strictly in enqueue order. The k-th dequeue is compared with the k-th accepted enqueue.
- R5: A dequeue 1 to WINDOW (10) cycles after an entry's enqueue is accepted. If no dequeue has arrived by cycle WINDOW after the enqueue, `late_err` pulses one cycle later and the entry is retired.
- R6: Only the first dequeue completes an entry. A later dequeue is checked against the next entry, or reports an underflow if no entry is pending.
- R7: The store holds at most DEPTH (10) pending entries. An enqueue that finds it full pulses `overflow_err` in the next cycle, and its data is dropped without taking a ticket.
- R8: A dequeue while nothing is pending pulses `underflow_err` in the next cycle and has no other effect.
- R9: An enqueue and a dequeue in the same cycle are both taken. The dequeue is judged against the older entry being served. If the store was empty, the dequeue underflows and the new entry stays pending.
- R10: The ticket and serving counters wrap at 2^16 without disturbing ordering or data checks.
- R11: Each retired entry produces exactly one of `match_ok`, `mismatch_err` or `late_err`, and never two at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_fire | input | 1 | An entry enters the watched queue this cycle |
| enq_data | input | 8 | Byte carried by the entering entry |
| deq_fire | input | 1 | An entry leaves the watched queue this cycle |
| deq_data | input | 8 | Byte carried by the leaving entry |
| match_ok | output | 1 | Served entry dequeued with correct data |
| mismatch_err | output | 1 | Served entry dequeued with wrong data |
| late_err | output | 1 | Served entry not dequeued within the window |
| overflow_err | output | 1 | Enqueue dropped because the store was full |
| underflow_err | output | 1 | Dequeue with no entry pending |

## Verification
The overflow case is the hardest to reach. Filling the store takes ten enqueues, and by the time the tenth is in, the head entry is already at the edge of its window. The stimulus therefore sends the overflowing enqueue in the same cycle as the first dequeue. It then drains the rest so that each entry leaves at exactly age ten, which also exercises the window boundary. A final dequeue shows that the dropped byte never took a ticket. Counter wrap needs more than 65,536 tickets, so a long stream runs one enqueue and one dequeue in every cycle.

// File: rtl/tkchk_pkg.sv
package tkchk_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE,
    VERDICT_MATCH,
    VERDICT_MISMATCH,
    VERDICT_LATE
  } verdict_e;
endpackage

// File: rtl/tkchk_seq_ctr.sv
module tkchk_seq_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (step) value <= value + 1'b1;
  end
endmodule

// File: rtl/tkchk_slot.sv
module tkchk_slot #(
  parameter int DATA_W = 8,
  parameter int WINDOW = 10,
  parameter int AGE_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] data,
  output logic [AGE_W-1:0]  age
);
  // age counts cycles since the write and holds once it reaches the window
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      age  <= '0;
    end else if (wr) begin
      data <= wr_data;
      age  <= AGE_W'(1);
    end else if (age < AGE_W'(WINDOW)) begin
      age <= age + 1'b1;
    end
  end
endmodule

// File: rtl/tkchk_judge.sv
module tkchk_judge
  import tkchk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WINDOW = 10,
  parameter int AGE_W  = 4
) (
  input  logic              pending,
  input  logic              deq_fire,
  input  logic [DATA_W-1:0] deq_data,
  input  logic [DATA_W-1:0] head_data,
  input  logic [AGE_W-1:0]  head_age,
  output verdict_e          verdict,
  output logic              retire,
  output logic              starved
);
  always_comb begin
    verdict = VERDICT_NONE;
    starved = 1'b0;
    if (!pending) begin
      starved = deq_fire;
    end else if (deq_fire) begin
      verdict = (deq_data == head_data) ? VERDICT_MATCH : VERDICT_MISMATCH;
    end else if (head_age >= AGE_W'(WINDOW)) begin
      verdict = VERDICT_LATE;
    end
    retire = (verdict != VERDICT_NONE);
  end
endmodule

// File: rtl/ordq_ticket_checker.sv
module ordq_ticket_checker
  import tkchk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 10,
  parameter int WINDOW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq_fire,
  input  logic [DATA_W-1:0] enq_data,
  input  logic              deq_fire,
  input  logic [DATA_W-1:0] deq_data,
  output logic              match_ok,
  output logic              mismatch_err,
  output logic              late_err,
  output logic              overflow_err,
  output logic              underflow_err
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SLOTS = 1 << IDX_W;
  localparam int AGE_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0]  ticket, serving, pend_cnt;
  logic              pending, full, enq_ok;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic [AGE_W-1:0]  slot_age  [SLOTS];
  logic [DATA_W-1:0] head_data;
  logic [AGE_W-1:0]  head_age;
  verdict_e          verdict;
  logic              retire, starved;

  // occupancy is the distance between the two counters; wraps cleanly
  assign pend_cnt = ticket - serving;
  assign pending  = (pend_cnt != '0);
  assign full     = (pend_cnt == CNT_W'(DEPTH));
  assign enq_ok   = enq_fire && !full;
  assign wr_idx   = ticket[IDX_W-1:0];
  assign rd_idx   = serving[IDX_W-1:0];

  tkchk_seq_ctr #(.W(CNT_W)) u_ticket (
    .clk(clk), .rst(rst), .step(enq_ok), .value(ticket)
  );

  tkchk_seq_ctr #(.W(CNT_W)) u_serving (
    .clk(clk), .rst(rst), .step(retire), .value(serving)
  );

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    tkchk_slot #(.DATA_W(DATA_W), .WINDOW(WINDOW), .AGE_W(AGE_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr      (enq_ok && (wr_idx == IDX_W'(gi))),
      .wr_data (enq_data),
      .data    (slot_data[gi]),
      .age     (slot_age[gi])
    );
  end

  assign head_data = slot_data[rd_idx];
  assign head_age  = slot_age[rd_idx];

  tkchk_judge #(.DATA_W(DATA_W), .WINDOW(WINDOW), .AGE_W(AGE_W)) u_judge (
    .pending   (pending),
    .deq_fire  (deq_fire),
    .deq_data  (deq_data),
    .head_data (head_data),
    .head_age  (head_age),
    .verdict   (verdict),
    .retire    (retire),
    .starved   (starved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_ok      <= 1'b0;
      mismatch_err  <= 1'b0;
      late_err      <= 1'b0;
      overflow_err  <= 1'b0;
      underflow_err <= 1'b0;
    end else begin
      match_ok      <= (verdict == VERDICT_MATCH);
      mismatch_err  <= (verdict == VERDICT_MISMATCH);
      late_err      <= (verdict == VERDICT_LATE);
      overflow_err  <= enq_fire && full;
      underflow_err <= starved;
    end
  end
endmodule

// File: rtl/ordq_ticket_checker_sva.sv
module ordq_ticket_checker_sva #(
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 10,
  parameter int WINDOW = 10,
  parameter int AGE_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_fire,
  input logic             deq_fire,
  input logic             match_ok,
  input logic             mismatch_err,
  input logic             late_err,
  input logic             overflow_err,
  input logic             underflow_err,
  input logic [CNT_W-1:0] pend_cnt,
  input logic [AGE_W-1:0] head_age
);
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({match_ok, mismatch_err, late_err})); // R11

  AST_MATCH_FROM_POP: assert property (@(posedge clk) disable iff (rst)
    match_ok |-> $past(deq_fire)); // R2

  AST_MISMATCH_FROM_POP: assert property (@(posedge clk) disable iff (rst)
    mismatch_err |-> $past(deq_fire)); // R3

  AST_LATE_AT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    late_err |-> ($past(head_age) == AGE_W'(WINDOW) && !$past(deq_fire))); // R5

  AST_AGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (pend_cnt != '0) |-> (head_age <= AGE_W'(WINDOW))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= CNT_W'(DEPTH)); // R7

  AST_OVERFLOW_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    overflow_err |-> ($past(enq_fire) && $past(pend_cnt) == CNT_W'(DEPTH))); // R7

  AST_UNDERFLOW_EMPTY: assert property (@(posedge clk) disable iff (rst)
    underflow_err |-> ($past(pend_cnt) == '0 && !match_ok && !mismatch_err && !late_err)); // R8
endmodule

bind ordq_ticket_checker ordq_ticket_checker_sva #(
  .CNT_W(CNT_W), .DEPTH(DEPTH), .WINDOW(WINDOW), .AGE_W(AGE_W)
) u_sva (
  .clk           (clk),
  .rst           (rst),
  .enq_fire      (enq_fire),
  .deq_fire      (deq_fire),
  .match_ok      (match_ok),
  .mismatch_err  (mismatch_err),
  .late_err      (late_err),
  .overflow_err  (overflow_err),
  .underflow_err (underflow_err),
  .pend_cnt      (pend_cnt),
  .head_age      (head_age)
);

// File: tb/ordq_ticket_checker_test.sv
module ordq_ticket_checker_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enq_fire = 1'b0;
  logic [7:0] enq_data = '0;
  logic       deq_fire = 1'b0;
  logic [7:0] deq_data = '0;
  logic       match_ok, mismatch_err, late_err, overflow_err, underflow_err;
  logic [4:0] obs;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ordq_ticket_checker uut (
    .clk(clk), .rst(rst),
    .enq_fire(enq_fire), .enq_data(enq_data),
    .deq_fire(deq_fire), .deq_data(deq_data),
    .match_ok(match_ok), .mismatch_err(mismatch_err), .late_err(late_err),
    .overflow_err(overflow_err), .underflow_err(underflow_err)
  );

  // packed view: {match, mismatch, late, overflow, underflow}
  assign obs = {match_ok, mismatch_err, late_err, overflow_err, underflow_err};

  // vector: {enq, enq_data, deq, deq_data, expected result bits}
  localparam int NVEC = 11;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 1'b1, 8'h00, 5'b00001},
    {1'b1, 8'hA5, 1'b0, 8'h00, 5'b00000},
    {1'b0, 8'h00, 1'b1, 8'hA5, 5'b10000},
    {1'b1, 8'h11, 1'b0, 8'h00, 5'b00000},
    {1'b1, 8'h22, 1'b0, 8'h00, 5'b00000},
    {1'b0, 8'h00, 1'b1, 8'h11, 5'b10000},
    {1'b0, 8'h00, 1'b1, 8'h99, 5'b01000},
    {1'b0, 8'h00, 1'b1, 8'h22, 5'b00001},
    {1'b1, 8'h33, 1'b1, 8'h00, 5'b00001},
    {1'b1, 8'h44, 1'b1, 8'h33, 5'b10000},
    {1'b0, 8'h00, 1'b1, 8'h44, 5'b10000}
  };

  function automatic string vec_req(int i);
    case (i)
      0:       return "R8";
      1, 2:    return "R2";
      3, 4, 5: return "R4";
      6:       return "R3 R11";
      7:       return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, logic [4:0] got, logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (match,mismatch,late,ovf,udf)", req, got, exp);
    end
  endtask

  // one cycle of stimulus; outputs sampled just after the edge that registers its result
  task automatic step(logic e, logic [7:0] ed, logic d, logic [7:0] dd);
    @(negedge clk);
    enq_fire = e; enq_data = ed; deq_fire = d; deq_data = dd;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; enq_fire = 1'b0; deq_fire = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", obs, 5'b00000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(190000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    do_reset();

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][22], VEC[i][21:14], VEC[i][13], VEC[i][12:5]);
      chk(vec_req(i), obs, VEC[i][4:0]);
    end

    // R5: dequeue exactly WINDOW cycles after enqueue is still on time
    step(1'b1, 8'h6C, 1'b0, 8'h00);
    for (int k = 1; k < 10; k++) step(1'b0, 8'h00, 1'b0, 8'h00);
    chk("R5", obs, 5'b00000);
    step(1'b0, 8'h00, 1'b1, 8'h6C);
    chk("R5", obs, 5'b10000);

    // R5: no dequeue by cycle WINDOW gives a late pulse and retires the entry
    step(1'b1, 8'h5A, 1'b0, 8'h00);
    for (int k = 1; k < 10; k++) step(1'b0, 8'h00, 1'b0, 8'h00);
    chk("R5", obs, 5'b00000);
    step(1'b0, 8'h00, 1'b0, 8'h00);
    chk("R5", obs, 5'b00100);
    step(1'b0, 8'h00, 1'b1, 8'h5A);
    chk("R5", obs, 5'b00001);

    // R7: fill to DEPTH, overflow in the cycle of the first dequeue
    for (int k = 0; k < 10; k++) step(1'b1, 8'(8'hC0 + k), 1'b0, 8'h00);
    step(1'b1, 8'hEE, 1'b1, 8'hC0);
    chk("R7", obs, 5'b10010);
    bad = 0;
    for (int k = 1; k < 10; k++) begin
      step(1'b0, 8'h00, 1'b1, 8'(8'hC0 + k));
      if (obs !== 5'b10000) bad++;
    end
    chk("R4", {4'b0, bad != 0}, 5'b00000);
    step(1'b0, 8'h00, 1'b1, 8'hEE);
    chk("R7", obs, 5'b00001);

    // R10: long stream wraps both counters
    step(1'b1, 8'h00, 1'b0, 8'h00);
    bad = 0;
    for (int i = 1; i <= 70000; i++) begin
      step(1'b1, 8'(i), 1'b1, 8'(i - 1));
      if (obs !== 5'b10000) bad++;
    end
    chk("R10", {4'b0, bad != 0}, 5'b00000);
    step(1'b0, 8'h00, 1'b1, 8'(70000));
    chk("R10", obs, 5'b10000);

    // R1: reset in the middle of traffic empties the store
    step(1'b1, 8'h12, 1'b0, 8'h00);
    step(1'b1, 8'h34, 1'b0, 8'h00);
    do_reset();
    step(1'b0, 8'h00, 1'b1, 8'h12);
    chk("R1", obs, 5'b00001);

    // R8: underflow leaves later traffic unaffected
    step(1'b1, 8'h77, 1'b0, 8'h00);
    step(1'b0, 8'h00, 1'b1, 8'h77);
    chk("R8", obs, 5'b10000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule